// File: doc/BRIEF.md
# Barrel Multithread Issue Scheduler

This block picks one hardware thread per clock cycle to issue an instruction, in the manner of a barrel processor. It holds a small state record for each of up to 128 thread slots: whether the slot is in use, whether it is eligible to issue, and whether it is waiting out a fixed latency or a memory reply. Each cycle it grants a ready thread. Moving from one thread to another costs no cycles, so long memory delays of many tens of cycles are hidden by interleaving other threads.

Threads are started and stopped through an activate port and a kill port. In the cycle a thread issues, the pipeline reports what that instruction waits on. A fixed count of cycles parks the thread on a countdown. A memory access parks it until a completion carrying its thread ID arrives. Among the eligible threads, the grant rotates, starting just after the thread that issued most recently. As a result, back-to-back slots seldom go to the same thread when several are ready. The grant outputs depend only on registered state, so the latency report for an issue can be returned in the same cycle.

Top module: `barrel_issue_sched`

## Requirements
- R1: After reset no thread is active, `issue_valid` is 0 and `issue_tid` is 0. The first grant goes to the lowest ready thread ID.
- R2: `act_valid` with an idle thread `act_tid` makes that thread ready from the next cycle. Activating a thread that is already active has no effect on its state.
- R3: When any thread is ready, `issue_valid` is 1 and `issue_tid` is the first ready thread found by scanning upward from one past the last issued ID, wrapping from NUM_THREADS-1 to 0. Consecutive cycles may grant different threads with no idle cycle between them.
- R4: When no thread is ready, `issue_valid` is 0 and `issue_tid` is 0.
- R5: An issue with `lat_valid`=1, `lat_mem`=0 and `lat_cycles`=L>0 makes that thread ineligible for exactly the next L cycles. It is eligible again in the (L+1)-th cycle after the issue. With L=0 the thread stays ready.
- R6: An issue with `lat_valid`=1 and `lat_mem`=1 makes the thread ineligible until a cycle with `cmpl_valid`=1 and `cmpl_tid` equal to its ID. It is ready in the cycle after that completion. A completion naming any other thread, or a thread not waiting on memory, has no effect.
- R7: `kill_valid` makes thread `kill_tid` idle in the next cycle, whatever its state. Kill takes priority over a simultaneous activate or issue report for the same thread. A killed thread is never granted until it is activated again.
- R8: A latency report (`lat_valid`) in a cycle with `issue_valid`=0 is ignored.
- R9: A ready thread is always an active thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate request |
| act_tid | input | TID_W | Thread to activate |
| kill_valid | input | 1 | Kill request |
| kill_tid | input | TID_W | Thread to kill |
| lat_valid | input | 1 | Latency report for the thread granted this cycle |
| lat_mem | input | 1 | 1: memory access, wait for completion; 0: fixed countdown |
| lat_cycles | input | LAT_W | Fixed latency in cycles when `lat_mem`=0 |
| cmpl_valid | input | 1 | Memory completion event |
| cmpl_tid | input | TID_W | Thread whose memory access completed |
| issue_valid | output | 1 | A thread is granted this cycle |
| issue_tid | output | TID_W | Granted thread ID (0 when none) |

## Verification
The bench drives a four-thread configuration through every fixed latency the count field can hold. For each latency it checks that the thread comes back on the exact cycle: an off-by-one countdown would regrant one cycle early or late. It sends completions to the wrong thread and to threads not waiting on memory; a scheduler that woke on any completion would grant a thread whose data has not arrived. Kills are aimed at the thread being granted and are paired with an activate of the same thread. Long mixed stretches check the grant wrap around NUM_THREADS-1. A rotation keyed to the grant slot instead of the last issued thread would break the expected order there.

// File: rtl/barrel_sched_pkg.sv
package barrel_sched_pkg;
   typedef enum logic [1:0] {
      TS_IDLE     = 2'd0,
      TS_READY    = 2'd1,
      TS_WAIT_CNT = 2'd2,
      TS_WAIT_MEM = 2'd3
   } tstate_e;
endpackage

// File: rtl/bsched_thread_slot.sv
module bsched_thread_slot
   import barrel_sched_pkg::*;
#(
   parameter int LAT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_hit,
   input  logic             kill_hit,
   input  logic             rep_hit,
   input  logic             rep_mem,
   input  logic [LAT_W-1:0] rep_lat,
   input  logic             cmpl_hit,
   output logic             is_active,
   output logic             is_ready
);
   tstate_e          st_q, st_d;
   logic [LAT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (kill_hit) begin
         st_d  = TS_IDLE;
         cnt_d = '0;
      end else if (act_hit && st_q == TS_IDLE) begin
         st_d = TS_READY;
      end else if (rep_hit) begin
         if (rep_mem) begin
            st_d = TS_WAIT_MEM;
         end else if (rep_lat != '0) begin
            st_d  = TS_WAIT_CNT;
            cnt_d = rep_lat;
         end
      end else if (st_q == TS_WAIT_CNT) begin
         if (cnt_q == LAT_W'(1)) begin
            st_d  = TS_READY;
            cnt_d = '0;
         end else begin
            cnt_d = cnt_q - LAT_W'(1);
         end
      end else if (st_q == TS_WAIT_MEM && cmpl_hit) begin
         st_d = TS_READY;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= TS_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign is_active = (st_q != TS_IDLE);
   assign is_ready  = (st_q == TS_READY);
endmodule

// File: rtl/bsched_rr_pick.sv
module bsched_rr_pick #(
   parameter int N     = 128,
   parameter int TID_W = 7
) (
   input  logic [N-1:0]     req,
   input  logic [TID_W-1:0] last,
   output logic             grant_valid,
   output logic [TID_W-1:0] grant_id
);
   logic [N-1:0]     above;
   logic [N-1:0]     req_hi;
   logic             hi_found, any_found;
   logic [TID_W-1:0] hi_id, any_id;

   for (genvar g = 0; g < N; g++) begin : g_mask
      assign above[g] = (TID_W'(g) > last);
   end

   assign req_hi = req & above;

   always_comb begin
      hi_found  = 1'b0;
      any_found = 1'b0;
      hi_id     = '0;
      any_id    = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_hi[i]) begin
            hi_found = 1'b1;
            hi_id    = TID_W'(i);
         end
         if (req[i]) begin
            any_found = 1'b1;
            any_id    = TID_W'(i);
         end
      end
   end

   assign grant_valid = any_found;
   assign grant_id    = hi_found ? hi_id : any_id;
endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched #(
   parameter int NUM_THREADS = 128,
   parameter int LAT_W       = 7,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_valid,
   input  logic [TID_W-1:0] act_tid,
   input  logic             kill_valid,
   input  logic [TID_W-1:0] kill_tid,
   input  logic             lat_valid,
   input  logic             lat_mem,
   input  logic [LAT_W-1:0] lat_cycles,
   input  logic             cmpl_valid,
   input  logic [TID_W-1:0] cmpl_tid,
   output logic             issue_valid,
   output logic [TID_W-1:0] issue_tid
);
   if (NUM_THREADS < 2 || NUM_THREADS > 128) begin : g_bad_threads
      $error("NUM_THREADS must lie in 2..128");
   end
   if (LAT_W < 1) begin : g_bad_lat
      $error("LAT_W must be at least 1");
   end

   logic [NUM_THREADS-1:0] active_vec;
   logic [NUM_THREADS-1:0] ready_vec;
   logic                   pick_valid;
   logic [TID_W-1:0]       pick_id;
   logic [TID_W-1:0]       last_q;
   logic                   rep_any;

   assign rep_any = lat_valid & pick_valid;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
      bsched_thread_slot #(.LAT_W(LAT_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .act_hit   (act_valid  && act_tid  == TID_W'(t)),
         .kill_hit  (kill_valid && kill_tid == TID_W'(t)),
         .rep_hit   (rep_any    && pick_id  == TID_W'(t)),
         .rep_mem   (lat_mem),
         .rep_lat   (lat_cycles),
         .cmpl_hit  (cmpl_valid && cmpl_tid == TID_W'(t)),
         .is_active (active_vec[t]),
         .is_ready  (ready_vec[t])
      );
   end

   bsched_rr_pick #(.N(NUM_THREADS), .TID_W(TID_W)) u_pick (
      .req         (ready_vec),
      .last        (last_q),
      .grant_valid (pick_valid),
      .grant_id    (pick_id)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          last_q <= TID_W'(NUM_THREADS - 1);
      else if (pick_valid) last_q <= pick_id;
   end

   assign issue_valid = pick_valid;
   assign issue_tid   = pick_valid ? pick_id : '0;
endmodule

// File: rtl/bsched_checker.sv
module bsched_checker #(
   parameter int N     = 128,
   parameter int TID_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N-1:0]     ready_vec,
   input logic [N-1:0]     active_vec,
   input logic             issue_valid,
   input logic [TID_W-1:0] issue_tid,
   input logic             kill_valid,
   input logic [TID_W-1:0] kill_tid,
   input logic             lat_valid,
   input logic             lat_mem
);
   assert_grant_is_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> ready_vec[issue_tid]);

   assert_work_conserving_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_vec != '0) |-> issue_valid);

   assert_idle_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_vec == '0) |-> (!issue_valid && issue_tid == '0));

   assert_mem_parks_thread_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && lat_valid && lat_mem && !(kill_valid && kill_tid == issue_tid))
      |=> !ready_vec[$past(issue_tid)]);

   assert_kill_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      kill_valid |=> !active_vec[$past(kill_tid)]);

   assert_ready_in_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_vec & ~active_vec) == '0);
endmodule

bind barrel_issue_sched bsched_checker #(.N(NUM_THREADS), .TID_W(TID_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ready_vec   (ready_vec),
   .active_vec  (active_vec),
   .issue_valid (issue_valid),
   .issue_tid   (issue_tid),
   .kill_valid  (kill_valid),
   .kill_tid    (kill_tid),
   .lat_valid   (lat_valid),
   .lat_mem     (lat_mem)
);

// File: tb/tb_barrel_issue_sched.sv
module tb_barrel_issue_sched;
   localparam int NT = 4;
   localparam int LW = 4;
   localparam int TW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          act_valid = 0, kill_valid = 0, lat_valid = 0, lat_mem = 0, cmpl_valid = 0;
   logic [TW-1:0] act_tid = 0, kill_tid = 0, cmpl_tid = 0;
   logic [LW-1:0] lat_cycles = 0;
   logic          issue_valid;
   logic [TW-1:0] issue_tid;

   int vectors = 0;
   int fails   = 0;
   int mst  [NT];   // 0 idle, 1 ready, 2 countdown, 3 memory wait
   int mcnt [NT];
   int mlast = NT - 1;

   always #4 clk = ~clk;

   barrel_issue_sched #(.NUM_THREADS(NT), .LAT_W(LW)) dut (
      .clk(clk), .rst_n(rst_n),
      .act_valid(act_valid), .act_tid(act_tid),
      .kill_valid(kill_valid), .kill_tid(kill_tid),
      .lat_valid(lat_valid), .lat_mem(lat_mem), .lat_cycles(lat_cycles),
      .cmpl_valid(cmpl_valid), .cmpl_tid(cmpl_tid),
      .issue_valid(issue_valid), .issue_tid(issue_tid)
   );

   task automatic exp_pick(output logic ev, output int et);
      ev = 0; et = 0;
      for (int k = 1; k <= NT; k++) begin
         int j;
         j = (mlast + k) % NT;
         if (!ev && mst[j] == 1) begin ev = 1; et = j; end
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   task automatic clear_in();
      act_valid = 0; kill_valid = 0; lat_valid = 0; lat_mem = 0; cmpl_valid = 0;
      act_tid = 0; kill_tid = 0; cmpl_tid = 0; lat_cycles = 0;
   endtask

   // Inputs are already set (at the falling edge); compare, then advance the model at the rising edge.
   task automatic cyc(input string req);
      logic ev; int et;
      #1;
      exp_pick(ev, et);
      vectors++;
      if (issue_valid !== ev || issue_tid !== TW'(et)) begin
         fails++;
         $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                  req, issue_valid, issue_tid, ev, et);
      end
      @(posedge clk);
      for (int i = 0; i < NT; i++) begin
         if (kill_valid && kill_tid == TW'(i)) begin
            mst[i] = 0; mcnt[i] = 0;
         end else if (act_valid && act_tid == TW'(i) && mst[i] == 0) begin
            mst[i] = 1;
         end else if (ev && et == i && lat_valid) begin
            if (lat_mem) mst[i] = 3;
            else if (lat_cycles != 0) begin mst[i] = 2; mcnt[i] = int'(lat_cycles); end
         end else if (mst[i] == 2) begin
            if (mcnt[i] == 1) begin mst[i] = 1; mcnt[i] = 0; end
            else mcnt[i] = mcnt[i] - 1;
         end else if (mst[i] == 3 && cmpl_valid && cmpl_tid == TW'(i)) begin
            mst[i] = 1;
         end
      end
      if (ev) mlast = et;
      @(negedge clk);
      clear_in();
   endtask

   task automatic kill_all();
      for (int i = 0; i < NT; i++) begin
         kill_valid = 1; kill_tid = TW'(i); cyc("R7");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got no finish, expected end of run");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NT; i++) begin mst[i] = 0; mcnt[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state, nothing granted
      cyc("R1"); cyc("R1");
      // R2: activate 2 then 0; first grant lowest ready (R1), re-activate active thread
      act_valid = 1; act_tid = 2; cyc("R2");
      act_valid = 1; act_tid = 0; cyc("R1");
      act_valid = 1; act_tid = 2; cyc("R2");
      act_valid = 1; act_tid = 1; cyc("R2");
      act_valid = 1; act_tid = 3; cyc("R2");
      // R3: all ready, rotation with wrap
      repeat (9) cyc("R3");
      // R8: reports with nothing ready are ignored
      kill_all();
      lat_valid = 1; lat_mem = 1; cyc("R8");
      lat_valid = 1; lat_cycles = 5; cyc("R8");
      act_valid = 1; act_tid = 1; cyc("R8");
      cyc("R8");
      // R5: every fixed latency on one thread, then with a second thread interleaved
      for (int l = 0; l < (1 << LW); l++) begin
         lat_valid = 1; lat_cycles = LW'(l); cyc("R5");
         repeat (l + 1) cyc("R5");
      end
      act_valid = 1; act_tid = 3; cyc("R5");
      for (int l = 1; l < (1 << LW); l++) begin
         lat_valid = 1; lat_cycles = LW'(l); cyc("R5");
         repeat (l + 1) cyc("R5");
      end
      // R6: memory wait, wrong completions, right completion
      kill_all();
      act_valid = 1; act_tid = 0; cyc("R6");
      lat_valid = 1; lat_mem = 1; cyc("R6");
      cmpl_valid = 1; cmpl_tid = 2; cyc("R6");
      act_valid = 1; act_tid = 1; cmpl_valid = 1; cmpl_tid = 1; cyc("R6");
      lat_valid = 1; lat_mem = 1; cyc("R6");
      repeat (60) cyc("R6");
      cmpl_valid = 1; cmpl_tid = 0; cyc("R6");
      repeat (3) cyc("R6");
      cmpl_valid = 1; cmpl_tid = 1; cyc("R6");
      repeat (3) cyc("R6");
      // R7: kill the granted thread while it reports; kill and activate same thread together
      act_valid = 1; act_tid = 2; cyc("R7");
      kill_valid = 1; kill_tid = issue_tid; lat_valid = 1; lat_mem = 1; cyc("R7");
      kill_valid = 1; kill_tid = 2; act_valid = 1; act_tid = 2; cyc("R7");
      repeat (6) cyc("R7");
      act_valid = 1; act_tid = 2; cyc("R7");
      repeat (4) cyc("R7");
      // Mixed stimulus across all requirements (R3, R5, R6, R7, R9)
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 16);
         act_valid  = ($urandom % 4) == 0; act_tid  = TW'($urandom);
         kill_valid = ($urandom % 16) == 0; kill_tid = TW'($urandom);
         cmpl_valid = ($urandom % 3) == 0; cmpl_tid = TW'($urandom);
         lat_valid  = ($urandom % 2) == 0;
         lat_mem    = r < 4;
         lat_cycles = LW'($urandom);
         cyc("R3");
      end
      summary();
      $finish;
   end
endmodule